// File: doc/BRIEF.md
# Multi-Line Level Interrupt Controller

The block collects nine level-sensitive interrupt sources and steers them onto three active-high request lines. Each source passes through a two-flop synchronizer and is compared with its active level. Sources 1 and 8 are always active-high and source 2 is always active-low. The remaining six sources take their level from a writable polarity register. Whenever a source sits at its active level, it is latched as pending in every line's pending set. A line raises its request while at least one source is both pending and enabled in that line's own mask. Software acknowledges a source by writing a one to its pending bit in the line register. If the source is still at its active level, the bit sets again.

Access goes through a 32-bit register port with a valid/write handshake, driven by a two-state machine. In PS_IDLE, `req_ready` is high and the port accepts a request. A write takes effect on the accepting edge, and the machine stays in PS_IDLE. A read moves the machine to PS_RESP (transition IDLE->RESP). For that one cycle `rsp_valid` is high, `rsp_rdata` holds the value and `req_ready` is low. The next edge returns the machine to PS_IDLE (transition RESP->IDLE). Offsets are decoded from address bits 5:2. Offset 0x00 is polarity, line n sits at 0x04 + 4*n, and offsets 0x10 to 0x3C are unmapped.

Top module: `lic_top`

## Requirements
- R1: After reset all request lines are low, all masks and pending bits are zero, and the polarity register reads 0x00000102 (programmable sources active-low).
- R2: Polarity register bit k (k in 0, 3..7) set to 1 makes source k active-high, and cleared to 0 makes it active-low.
- R3: Sources 1 and 8 are fixed active-high and source 2 is fixed active-low. Writes to polarity bits 1, 2 and 8 are ignored, and those bits read as 1, 0 and 1.
- R4: Polarity reads return the effective levels in bits 8:0 with zeros above. Reads of offsets 0x10 to 0x3C return zero, and writes to them change nothing.
- R5: A source that reaches its active level becomes pending on every line, whatever the masks are. It stays pending after the input goes inactive, until it is acknowledged.
- R6: Request line n is high exactly when some source is pending and has its mask bit (bit k of line n's register) set. Each line is independent of the others.
- R7: A write to line n's register loads the mask from bits 8:0. A one in bit 16+k clears source k's pending bit on line n, and a zero there leaves it unchanged.
- R8: If a source is still at its active level when it is acknowledged, its pending bit stays set. A set wins over a clear in the same cycle.
- R9: A read of line n returns the mask in bits 8:0, pending AND mask in bits 24:16, and zero in every other bit.
- R10: When an input changes at its pin, the pending bit and the request line follow it on the third rising clock edge.
- R11: A read accepted while `req_ready` is high gets exactly one `rsp_valid` cycle on the next cycle. `req_ready` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 9 | Raw interrupt source levels |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Port can accept a request (PS_IDLE) |
| rsp_valid | output | 1 | Read data valid (PS_RESP) |
| rsp_rdata | output | 32 | Read data, zero when not valid |
| irq_out | output | 3 | Request lines, active high |

## Verification
A sweep covers every source on every line under both polarity settings. Each source is pulsed to its active level for two cycles. The sweep checks that only the enabled line rises and that the pending bit outlives the pulse. It also checks that an acknowledge clears the bit, and that enabling the same source later on another line shows the pending bit that line latched. Three directed patterns cover the remaining behaviour. A source held active through its acknowledge shows that a set wins over a clear. Two sources pending at once show that a zero in a pending bit leaves that bit alone. Cycle-by-cycle sampling after an input edge pins down the three-edge latency, and polarity writes show the fixed bits cannot be changed.

// File: rtl/lic_pkg.sv
package lic_pkg;

    parameter int NUM_SRC   = 9;
    parameter int NUM_LINES = 3;
    parameter int DATA_W    = 32;
    parameter int ADDR_W    = 6;
    parameter int PEND_LSB  = 16;

    // sources with a level that software cannot change
    parameter logic [NUM_SRC-1:0] FIXED_HIGH = 9'h102;
    parameter logic [NUM_SRC-1:0] FIXED_LOW  = 9'h004;

    typedef enum logic [0:0] {
        PS_IDLE = 1'b0,
        PS_RESP = 1'b1
    } port_state_e;

endpackage

// File: rtl/lic_level_detect.sv
module lic_level_detect
    import lic_pkg::*;
#(
    parameter int                NS     = NUM_SRC,
    parameter logic [NS-1:0]     FIX_HI = FIXED_HIGH,
    parameter logic [NS-1:0]     FIX_LO = FIXED_LOW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src_in,
    input  logic          pol_we,
    input  logic [NS-1:0] pol_wdata,
    output logic [NS-1:0] active,
    output logic [NS-1:0] pol_eff
);

    // reset level of the synchronizer: the inactive level under reset polarity
    localparam logic [NS-1:0] SYNC_RST = ~FIX_HI;

    logic [NS-1:0] meta_q;
    logic [NS-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= SYNC_RST;
            sync_q <= SYNC_RST;
        end else begin
            meta_q <= src_in;
            sync_q <= meta_q;
        end
    end

    for (genvar k = 0; k < NS; k++) begin : g_src
        if (FIX_HI[k]) begin : g_hi
            assign pol_eff[k] = 1'b1;
        end else if (FIX_LO[k]) begin : g_lo
            assign pol_eff[k] = 1'b0;
        end else begin : g_prog
            logic pol_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pol_q <= 1'b0;
                end else if (pol_we) begin
                    pol_q <= pol_wdata[k];
                end
            end
            assign pol_eff[k] = pol_q;
        end
        assign active[k] = ~(sync_q[k] ^ pol_eff[k]);
    end

endmodule

// File: rtl/lic_line_bank.sv
module lic_line_bank
    import lic_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int DW = DATA_W,
    parameter int PL = PEND_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] active,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [NS-1:0] mask_q,
    output logic [NS-1:0] pend_q,
    output logic          irq
);

    logic [NS-1:0] clr;
    logic [NS-1:0] pend_d;

    always_comb begin
        clr    = wr_en ? wr_data[PL+NS-1:PL] : '0;
        pend_d = (pend_q & ~clr) | active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (wr_en) begin
                mask_q <= wr_data[NS-1:0];
            end
        end
    end

    assign irq = |(pend_q & mask_q);

endmodule

// File: rtl/lic_reg_port.sv
module lic_reg_port
    import lic_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int NL = NUM_LINES,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int PL = PEND_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             pol_we,
    output logic [NL-1:0]    line_we,
    output logic [DW-1:0]    wr_data,
    input  logic [NS-1:0]    pol_eff,
    input  logic [NL*NS-1:0] mask_flat,
    input  logic [NL*NS-1:0] pend_flat
);

    localparam int IW = AW - 2;

    port_state_e   state_q, state_d;
    logic [IW-1:0] rd_idx_q;
    logic [IW-1:0] req_idx;
    logic          accept;

    assign req_idx = req_addr[AW-1:2];
    assign accept  = req_valid && req_ready;
    assign wr_data = req_wdata;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            rd_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept && !req_write) begin
                rd_idx_q <= req_idx;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (accept && !req_write) state_d = PS_RESP;
            PS_RESP: state_d = PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        pol_we    = 1'b0;
        line_we   = '0;
        unique case (state_q)
            PS_IDLE: begin
                req_ready = 1'b1;
                if (req_valid && req_write) begin
                    pol_we = (req_idx == '0);
                    for (int n = 0; n < NL; n++) begin
                        line_we[n] = (req_idx == IW'(n + 1));
                    end
                end
            end
            PS_RESP: begin
                rsp_valid = 1'b1;
                if (rd_idx_q == '0) begin
                    rsp_rdata[NS-1:0] = pol_eff;
                end
                for (int n = 0; n < NL; n++) begin
                    if (rd_idx_q == IW'(n + 1)) begin
                        rsp_rdata[NS-1:0]     = mask_flat[n*NS +: NS];
                        rsp_rdata[PL+NS-1:PL] = mask_flat[n*NS +: NS] & pend_flat[n*NS +: NS];
                    end
                end
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lic_top.sv
module lic_top
    import lic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_in,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [NUM_LINES-1:0] irq_out
);

    localparam int NS = NUM_SRC;
    localparam int NL = NUM_LINES;

    logic [NS-1:0]    src_active;
    logic [NS-1:0]    pol_eff;
    logic             pol_we;
    logic [NL-1:0]    line_we;
    logic [DATA_W-1:0] wr_data;
    logic [NL*NS-1:0] mask_flat;
    logic [NL*NS-1:0] pend_flat;

    lic_level_detect #(.NS(NS), .FIX_HI(FIXED_HIGH), .FIX_LO(FIXED_LOW)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .pol_we    (pol_we),
        .pol_wdata (wr_data[NS-1:0]),
        .active    (src_active),
        .pol_eff   (pol_eff)
    );

    for (genvar n = 0; n < NL; n++) begin : g_line
        lic_line_bank #(.NS(NS), .DW(DATA_W), .PL(PEND_LSB)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (src_active),
            .wr_en   (line_we[n]),
            .wr_data (wr_data),
            .mask_q  (mask_flat[n*NS +: NS]),
            .pend_q  (pend_flat[n*NS +: NS]),
            .irq     (irq_out[n])
        );
    end

    lic_reg_port #(.NS(NS), .NL(NL), .DW(DATA_W), .AW(ADDR_W), .PL(PEND_LSB)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .pol_we    (pol_we),
        .line_we   (line_we),
        .wr_data   (wr_data),
        .pol_eff   (pol_eff),
        .mask_flat (mask_flat),
        .pend_flat (pend_flat)
    );

endmodule

// File: rtl/lic_checker.sv
module lic_checker
    import lic_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int NL = NUM_LINES,
    parameter int PL = PEND_LSB
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [NS-1:0]     src_active,
    input logic [NL*NS-1:0]  pend_flat,
    input logic [NL-1:0]     line_we,
    input logic [DATA_W-1:0] wr_data
);

    p_rsp_blocks_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_read_answered_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    for (genvar n = 0; n < NL; n++) begin : g_ln
        for (genvar k = 0; k < NS; k++) begin : g_sr
            p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_flat[n*NS+k] && !(line_we[n] && wr_data[PL+k])) |=> pend_flat[n*NS+k]);

            p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
                src_active[k] |=> pend_flat[n*NS+k]);

            p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (line_we[n] && wr_data[PL+k] && !src_active[k]) |=> !pend_flat[n*NS+k]);

            p_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend_flat[n*NS+k]) |-> $past(src_active[k]));
        end
    end

endmodule

bind lic_top lic_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .src_active (src_active),
    .pend_flat  (pend_flat),
    .line_we    (line_we),
    .wr_data    (wr_data)
);

// File: tb/sim_lic_top.sv
module sim_lic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  src_in = 9'h0FD;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [2:0]  irq_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [8:0] FHI  = 9'h102;
    localparam logic [8:0] PROG = 9'h0F9;

    always #2 clk = ~clk;

    lic_top u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        chk("R11 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk("R11 ready low", {31'd0, req_ready}, 32'd0);
        d = rsp_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int n = 0; n < 3; n++) wr(6'(4 + 4 * n), 32'h01FF0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [8:0]  eff, idle, pv;
        int m;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {29'd0, irq_out}, 32'd0);
        rd(6'h00, d); chk("R1 polarity", d, 32'h102);
        for (int n = 0; n < 3; n++) begin
            rd(6'(4 + 4 * n), d); chk("R1 line", d, 32'd0);
        end
        // R3 fixed bits ignore writes
        wr(6'h00, 32'h004); rd(6'h00, d); chk("R3 fixed readback", d, 32'h102);
        wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, d); chk("R3/R4 all ones", d, 32'h1FB);
        wr(6'h00, 32'h0);
        // R4 unmapped
        rd(6'h10, d); chk("R4 unmapped 0x10", d, 0);
        rd(6'h24, d); chk("R4 unmapped 0x24", d, 0);
        rd(6'h3C, d); chk("R4 unmapped 0x3C", d, 0);
        wr(6'h10, 32'h01FF01FF);
        for (int n = 0; n < 3; n++) begin
            rd(6'(4 + 4 * n), d); chk("R4 unmapped write", d, 32'd0);
        end

        // sweep: R2 R5 R6 R7 R9 over polarity x source x line
        for (int pi = 0; pi < 2; pi++) begin
            pv   = (pi == 0) ? 9'h000 : 9'h1FF;
            eff  = (pv & PROG) | FHI;
            idle = ~eff;
            for (int k = 0; k < 9; k++) begin
                for (int n = 0; n < 3; n++) begin
                    m = (n + 1) % 3;
                    wr(6'h00, {23'd0, pv});
                    @(negedge clk); src_in = idle;
                    wait_n(4);
                    clear_all();
                    rd(6'h00, d); chk("R2 polarity readback", d, {23'd0, eff});
                    wr(6'(4 + 4 * n), 32'(1 << k));
                    @(negedge clk);
                    chk("R6 idle low", {29'd0, irq_out}, 32'd0);
                    src_in = idle ^ 9'(1 << k);
                    wait_n(2);
                    src_in = idle;
                    wait_n(4);
                    chk("R5/R2 line raised", {29'd0, irq_out}, 32'(1 << n));
                    rd(6'(4 + 4 * n), d);
                    chk("R9 line read", d, 32'(1 << (16 + k)) | 32'(1 << k));
                    wr(6'(4 + 4 * n), 32'(1 << (16 + k)) | 32'(1 << k));
                    @(negedge clk);
                    chk("R7 ack drops line", {29'd0, irq_out}, 32'd0);
                    rd(6'(4 + 4 * n), d); chk("R7 mask kept", d, 32'(1 << k));
                    wr(6'(4 + 4 * m), 32'(1 << k));
                    @(negedge clk);
                    chk("R5/R6 other line latched", {29'd0, irq_out}, 32'(1 << m));
                    clear_all();
                end
            end
        end

        // R10 latency and R8 retrigger on source 3 (active low)
        wr(6'h00, 32'h0);
        @(negedge clk); src_in = 9'h0FD;
        wait_n(4);
        clear_all();
        wr(6'h04, 32'h8);
        @(negedge clk); src_in = 9'h0F5;
        @(negedge clk); chk("R10 edge1", {29'd0, irq_out}, 0);
        @(negedge clk); chk("R10 edge2", {29'd0, irq_out}, 0);
        @(negedge clk); chk("R10 edge3", {29'd0, irq_out}, 1);
        wr(6'h04, 32'h00080008);
        rd(6'h04, d); chk("R8 still pending", d, 32'h00080008);
        chk("R8 line high", {29'd0, irq_out}, 1);
        @(negedge clk); src_in = 9'h0FD;
        wait_n(4);
        wr(6'h04, 32'h00080008);
        rd(6'h04, d); chk("R8 cleared after release", d, 32'h8);

        // R7 selective clear with two pending sources (0 and 3, active low)
        wr(6'h04, 32'h9);
        @(negedge clk); src_in = 9'h0F4;
        wait_n(2);
        src_in = 9'h0FD;
        wait_n(4);
        rd(6'h04, d); chk("R7 both pending", d, 32'h00090009);
        wr(6'h04, 32'h00010009);
        rd(6'h04, d); chk("R7 zero leaves bit", d, 32'h00080009);
        chk("R7 line still high", {29'd0, irq_out}, 1);
        wr(6'h04, 32'h00080000);
        rd(6'h04, d); chk("R7 mask cleared", d, 32'h0);
        chk("R6 line low", {29'd0, irq_out}, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule